// File: doc/BRIEF.md
# Queued SPI Master Controller

This block is a memory-mapped SPI master that works through a queue of byte-wide transfers with no processor involvement once the queue is started. Software fills a transmit RAM and a per-slot command RAM, programs an inclusive range of slots with a first-slot and a last-slot pointer, and then sets a go bit. The engine shifts each slot out in ascending order (wrapping from the highest slot back to slot 0), captures the byte returned on the serial input into a receive RAM, and raises a sticky done flag plus a level interrupt request when the last slot of the range completes.

Serial timing is SPI mode 3: the serial clock idles high, data changes on the falling edge and is sampled on the rising edge, most significant bit first. The half-period of the serial clock equals a programmable divisor in system clocks, never below 8. Bit 7 of each slot's command byte chooses whether the single active-low chip select stays asserted into the next slot. On the last slot it chooses whether chip select is released when the queue ends or stays asserted for a later queue. A read-write lock bit and a stored word-format field are provided for software handshaking. While a queue runs, the divisor, the pointers and the transmit and command RAMs are write-protected.

Top module: `spiq_master`

## Requirements
- R1: After reset the divisor (addr 0x00) reads 8, the format field (addr 0x01) reads 0x23, both pointers, the control byte, the status byte and the lock byte read 0, cs_n and sck are 1 and irq is 0.
- R2: sck idles high; during a slot mosi changes only as sck falls and stays stable while sck is high; bits go out MSB first; the byte for slot n comes from transmit word 2n (addr 0x40 + 2n).
- R3: The byte sampled on miso at the eight rising sck edges of slot n, MSB first, is stored in receive word 2n+1 (addr 0x60 + 2n + 1, read-only).
- R4: A queue runs every slot from the first pointer (addr 0x02) to the last pointer (addr 0x03) inclusive in ascending order, wrapping from slot 15 to slot 0.
- R5: Command byte for slot n sits at addr 0x80 + n. With its bit 7 set on a slot that is not the last, cs_n stays low into the next slot; with bit 7 clear, cs_n goes high for one divisor period before the next slot.
- R6: On the last slot, command bit 7 clear releases cs_n after the slot; bit 7 set keeps cs_n low after the queue ends, until a later queue ends on a slot with bit 7 clear.
- R7: Control byte (addr 0x04): writing bit 6 as 1 while idle starts the queue; bit 6 reads 1 while the queue runs and clears itself when it finishes. Bit 5 enables the interrupt, bit 7 is a stored flag.
- R8: Status bit 0 (addr 0x05) sets when the last slot finishes; writing 0 to it clears it, writing 1 has no effect. irq is high exactly while status bit 0 and control bit 5 are both 1.
- R9: The sck half-period equals the divisor in system clocks; a divisor written below 8 is stored and used as 8.
- R10: Writes to the divisor, the pointers, the transmit RAM or the command RAM while a queue runs are ignored.
- R11: Addr 0x06 reads the index of the slot being processed.
- R12: Lock bit 0 (addr 0x07) and the 6-bit format field (addr 0x01) read back what was written and do not alter the transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register word address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr (combinational) |
| irq | output | 1 | Level interrupt request |
| sck | output | 1 | Serial clock, idles high |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Active-low chip select |

## Verification
The bench builds the block with its defaults: 16 slots, 8-bit data and divisor, a minimum divisor of 8 and the RAMs based at 0x40. With 16 slots, ranges that wrap from slot 15 to slot 0 and a full 16-slot queue are within reach, and the 8-bit divisor lets half-period measurements at 8 and 10 clocks and the clamp of a written value of 3 be observed. A bench-side slave returns a distinct byte per position so transmit order, receive placement at odd words and chip-select gaps can be told apart.

// File: rtl/spiq_pkg.sv
package spiq_pkg;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_RUN  = 2'd1,
        SQ_GAP  = 2'd2
    } seq_state_e;

    localparam logic [7:0] A_DIV   = 8'h00;
    localparam logic [7:0] A_FMT   = 8'h01;
    localparam logic [7:0] A_FIRST = 8'h02;
    localparam logic [7:0] A_LAST  = 8'h03;
    localparam logic [7:0] A_CTRL  = 8'h04;
    localparam logic [7:0] A_STAT  = 8'h05;
    localparam logic [7:0] A_CUR   = 8'h06;
    localparam logic [7:0] A_LOCK  = 8'h07;

    localparam int CTRL_CONT_BIT  = 7;
    localparam int CTRL_GO_BIT    = 6;
    localparam int CTRL_IRQEN_BIT = 5;
    localparam int CMD_HOLD_BIT   = 7;

    localparam logic [5:0] FMT_RESET = 6'h23;

endpackage

// File: rtl/spiq_bit_engine.sv
module spiq_bit_engine #(
    parameter int DW    = 8,
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [DW-1:0]    tx_byte,
    input  logic [DIV_W-1:0] half_div,
    input  logic             miso,
    output logic             sck,
    output logic             mosi,
    output logic             busy,
    output logic             done,
    output logic [DW-1:0]    rx_byte
);
    localparam int BIT_W = (DW > 1) ? $clog2(DW) : 1;

    typedef struct packed {
        logic             act;
        logic             low;
        logic [DIV_W-1:0] cnt;
        logic [BIT_W-1:0] bitn;
        logic [DW-1:0]    txs;
        logic [DW-1:0]    rxs;
        logic             sck;
        logic             mosi;
        logic             done;
    } eng_t;

    eng_t eng_d, eng_q;

    always_comb begin
        eng_d      = eng_q;
        eng_d.done = 1'b0;
        if (start && !eng_q.act) begin
            eng_d.act  = 1'b1;
            eng_d.low  = 1'b1;
            eng_d.cnt  = '0;
            eng_d.bitn = '0;
            eng_d.sck  = 1'b0;
            eng_d.mosi = tx_byte[DW-1];
            eng_d.txs  = tx_byte << 1;
        end else if (eng_q.act) begin
            if (eng_q.cnt == half_div - 1'b1) begin
                eng_d.cnt = '0;
                if (eng_q.low) begin
                    eng_d.low = 1'b0;
                    eng_d.sck = 1'b1;
                    eng_d.rxs = {eng_q.rxs[DW-2:0], miso};
                end else if (eng_q.bitn == BIT_W'(DW - 1)) begin
                    eng_d.act  = 1'b0;
                    eng_d.done = 1'b1;
                end else begin
                    eng_d.bitn = eng_q.bitn + 1'b1;
                    eng_d.low  = 1'b1;
                    eng_d.sck  = 1'b0;
                    eng_d.mosi = eng_q.txs[DW-1];
                    eng_d.txs  = eng_q.txs << 1;
                end
            end else begin
                eng_d.cnt = eng_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eng_q      <= '0;
            eng_q.sck  <= 1'b1;
            eng_q.mosi <= 1'b1;
        end else begin
            eng_q <= eng_d;
        end
    end

    assign sck     = eng_q.sck;
    assign mosi    = eng_q.mosi;
    assign busy    = eng_q.act;
    assign done    = eng_q.done;
    assign rx_byte = eng_q.rxs;

    // R2
    sck_idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !eng_q.act |-> eng_q.sck);

    // R2
    mosi_hold_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_q.sck && $past(eng_q.sck)) |-> $stable(eng_q.mosi));

endmodule

// File: rtl/spiq_queue_seq.sv
module spiq_queue_seq
    import spiq_pkg::*;
#(
    parameter int SLOTS = 16,
    parameter int CW    = 8,
    parameter int DIV_W = 8,
    localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [SLOT_W-1:0] q_first,
    input  logic [SLOT_W-1:0] q_last,
    input  logic [CW-1:0]     cmd_byte,
    input  logic [DIV_W-1:0]  half_div,
    input  logic              eng_done,
    input  logic              eng_busy,
    output logic              eng_start,
    output logic              cs_n,
    output logic [SLOT_W-1:0] cur,
    output logic              busy,
    output logic              rx_we,
    output logic              finish
);
    typedef struct packed {
        seq_state_e       state;
        logic [SLOT_W-1:0] cur;
        logic             cs_n;
        logic             start;
        logic [DIV_W-1:0] gap;
    } seq_t;

    seq_t seq_d, seq_q;

    function automatic logic [SLOT_W-1:0] next_slot(input logic [SLOT_W-1:0] s);
        return (s == SLOT_W'(SLOTS - 1)) ? '0 : s + 1'b1;
    endfunction

    always_comb begin
        seq_d       = seq_q;
        seq_d.start = 1'b0;
        rx_we       = 1'b0;
        finish      = 1'b0;
        unique case (seq_q.state)
            SQ_IDLE: begin
                if (go) begin
                    seq_d.state = SQ_RUN;
                    seq_d.cur   = q_first;
                    seq_d.cs_n  = 1'b0;
                    seq_d.start = 1'b1;
                end
            end
            SQ_RUN: begin
                if (eng_done) begin
                    rx_we = 1'b1;
                    if (seq_q.cur == q_last) begin
                        finish      = 1'b1;
                        seq_d.state = SQ_IDLE;
                        seq_d.cs_n  = !cmd_byte[CMD_HOLD_BIT];
                    end else if (cmd_byte[CMD_HOLD_BIT]) begin
                        seq_d.cur   = next_slot(seq_q.cur);
                        seq_d.start = 1'b1;
                    end else begin
                        seq_d.cs_n  = 1'b1;
                        seq_d.gap   = '0;
                        seq_d.state = SQ_GAP;
                    end
                end
            end
            SQ_GAP: begin
                if (seq_q.gap == half_div - 1'b1) begin
                    seq_d.state = SQ_RUN;
                    seq_d.cur   = next_slot(seq_q.cur);
                    seq_d.cs_n  = 1'b0;
                    seq_d.start = 1'b1;
                end else begin
                    seq_d.gap = seq_q.gap + 1'b1;
                end
            end
            default: seq_d.state = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q       <= '0;
            seq_q.state <= SQ_IDLE;
            seq_q.cs_n  <= 1'b1;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign eng_start = seq_q.start;
    assign cs_n      = seq_q.cs_n;
    assign cur       = seq_q.cur;
    assign busy      = (seq_q.state != SQ_IDLE);

    // R5
    cs_low_while_shifting_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_busy |-> !seq_q.cs_n);

    // R4
    slot_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(busy) && busy && !$stable(seq_q.cur)) |-> seq_q.cur == next_slot($past(seq_q.cur)));

endmodule

// File: rtl/spiq_master.sv
module spiq_master
    import spiq_pkg::*;
#(
    parameter int SLOTS   = 16,
    parameter int DW      = 8,
    parameter int AW      = 8,
    parameter int DIV_W   = 8,
    parameter int DIV_MIN = 8,
    parameter int TX_BASE = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_we,
    input  logic [AW-1:0] reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic          irq,
    output logic          sck,
    output logic          mosi,
    input  logic          miso,
    output logic          cs_n
);
    localparam int SLOT_W   = (SLOTS > 1) ? $clog2(SLOTS) : 1;
    localparam int WORDS    = 2 * SLOTS;
    localparam int WORD_W   = SLOT_W + 1;
    localparam int RX_BASE  = TX_BASE + WORDS;
    localparam int CMD_BASE = RX_BASE + WORDS;

    typedef struct packed {
        logic [DIV_W-1:0]               div;
        logic [5:0]                     fmt;
        logic [SLOT_W-1:0]              first;
        logic [SLOT_W-1:0]              last;
        logic                           go;
        logic                           irq_en;
        logic                           cont;
        logic                           done;
        logic                           lock;
        logic [WORDS-1:0][DW-1:0]       tx;
        logic [WORDS-1:0][DW-1:0]       rx;
        logic [SLOTS-1:0][DW-1:0]       cmd;
    } regs_t;

    regs_t r_d, r_q;

    logic              busy, eng_busy, eng_done, eng_start, rx_we, finish, go_pulse;
    logic [SLOT_W-1:0] cur;
    logic [DW-1:0]     eng_rx;
    logic [AW-1:0]     off_tx, off_rx, off_cmd;
    logic              in_tx, in_rx, in_cmd;

    assign off_tx  = reg_addr - AW'(TX_BASE);
    assign off_rx  = reg_addr - AW'(RX_BASE);
    assign off_cmd = reg_addr - AW'(CMD_BASE);
    assign in_tx   = off_tx  < AW'(WORDS);
    assign in_rx   = off_rx  < AW'(WORDS);
    assign in_cmd  = off_cmd < AW'(SLOTS);

    assign go_pulse = reg_we && (reg_addr == AW'(A_CTRL)) && reg_wdata[CTRL_GO_BIT] && !busy;

    always_comb begin
        r_d = r_q;
        if (reg_we) begin
            unique case (reg_addr)
                AW'(A_DIV): if (!busy) begin
                    r_d.div = (reg_wdata < DW'(DIV_MIN)) ? DIV_W'(DIV_MIN) : DIV_W'(reg_wdata);
                end
                AW'(A_FMT):   r_d.fmt = reg_wdata[5:0];
                AW'(A_FIRST): if (!busy) r_d.first = reg_wdata[SLOT_W-1:0];
                AW'(A_LAST):  if (!busy) r_d.last  = reg_wdata[SLOT_W-1:0];
                AW'(A_CTRL): begin
                    r_d.cont   = reg_wdata[CTRL_CONT_BIT];
                    r_d.irq_en = reg_wdata[CTRL_IRQEN_BIT];
                    if (!busy) r_d.go = reg_wdata[CTRL_GO_BIT];
                end
                AW'(A_STAT):  if (!reg_wdata[0]) r_d.done = 1'b0;
                AW'(A_LOCK):  r_d.lock = reg_wdata[0];
                default: ;
            endcase
            if (in_tx && !busy)  r_d.tx[off_tx[WORD_W-1:0]]   = reg_wdata;
            if (in_cmd && !busy) r_d.cmd[off_cmd[SLOT_W-1:0]] = reg_wdata;
        end
        if (rx_we) r_d.rx[{cur, 1'b1}] = eng_rx;
        if (finish) begin
            r_d.done = 1'b1;
            r_d.go   = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q     <= '0;
            r_q.div <= DIV_W'(DIV_MIN);
            r_q.fmt <= FMT_RESET;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            AW'(A_DIV):   reg_rdata = DW'(r_q.div);
            AW'(A_FMT):   reg_rdata = DW'(r_q.fmt);
            AW'(A_FIRST): reg_rdata = DW'(r_q.first);
            AW'(A_LAST):  reg_rdata = DW'(r_q.last);
            AW'(A_CTRL): begin
                reg_rdata[CTRL_CONT_BIT]  = r_q.cont;
                reg_rdata[CTRL_GO_BIT]    = r_q.go;
                reg_rdata[CTRL_IRQEN_BIT] = r_q.irq_en;
            end
            AW'(A_STAT):  reg_rdata = DW'(r_q.done);
            AW'(A_CUR):   reg_rdata = DW'(cur);
            AW'(A_LOCK):  reg_rdata = DW'(r_q.lock);
            default: begin
                if (in_tx)  reg_rdata = r_q.tx[off_tx[WORD_W-1:0]];
                if (in_rx)  reg_rdata = r_q.rx[off_rx[WORD_W-1:0]];
                if (in_cmd) reg_rdata = r_q.cmd[off_cmd[SLOT_W-1:0]];
            end
        endcase
    end

    assign irq = r_q.done && r_q.irq_en;

    spiq_queue_seq #(
        .SLOTS (SLOTS),
        .CW    (DW),
        .DIV_W (DIV_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (go_pulse),
        .q_first   (r_q.first),
        .q_last    (r_q.last),
        .cmd_byte  (r_q.cmd[cur]),
        .half_div  (r_q.div),
        .eng_done  (eng_done),
        .eng_busy  (eng_busy),
        .eng_start (eng_start),
        .cs_n      (cs_n),
        .cur       (cur),
        .busy      (busy),
        .rx_we     (rx_we),
        .finish    (finish)
    );

    spiq_bit_engine #(
        .DW    (DW),
        .DIV_W (DIV_W)
    ) u_eng (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (eng_start),
        .tx_byte  (r_q.tx[{cur, 1'b0}]),
        .half_div (r_q.div),
        .miso     (miso),
        .sck      (sck),
        .mosi     (mosi),
        .busy     (eng_busy),
        .done     (eng_done),
        .rx_byte  (eng_rx)
    );

    // R7
    go_self_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        finish |=> (!r_q.go && r_q.done));

    // R8
    done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.done && !(reg_we && reg_addr == AW'(A_STAT) && !reg_wdata[0])) |=> r_q.done);

    // R10
    last_ptr_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && reg_we && reg_addr == AW'(A_LAST)) |=> $stable(r_q.last));

    // R9
    div_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.div >= DIV_W'(DIV_MIN));

endmodule

// File: tb/spiq_master_bench.sv
module spiq_master_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 5;
    // {first, last, divisor, seed}
    localparam logic [23:0] VEC [NVEC] = '{
        {4'd0,  4'd0,  8'd8,  8'h11},
        {4'd0,  4'd3,  8'd8,  8'h22},
        {4'd2,  4'd6,  8'd9,  8'h33},
        {4'd14, 4'd1,  8'd12, 8'h44},
        {4'd0,  4'd15, 8'd8,  8'h55}
    };

    logic       clk = 0, rst_n = 0, reg_we = 0, miso = 1;
    logic [7:0] reg_addr = 0, reg_wdata = 0;
    logic [7:0] reg_rdata;
    logic       irq, sck, mosi, cs_n;

    int n_cmp = 0, n_bad = 0, cyc = 0, cs_rise = 0;
    bit summary_done = 0;

    // bench-side slave
    int         sb = 0, bitc = 0;
    logic [7:0] seed_v = 0, cap = 0;
    logic [7:0] mosi_log [32];

    spiq_master u_spiq_master (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .sck(sck), .mosi(mosi), .miso(miso), .cs_n(cs_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;
    always @(posedge cs_n) cs_rise = cs_rise + 1;

    function automatic logic [7:0] resp(input int k, input logic [7:0] s);
        return 8'h5A ^ (8'(k) * 8'd37) ^ s;
    endfunction

    function automatic logic [7:0] txv(input int n, input logic [7:0] s);
        return 8'h3C ^ (8'(n) * 8'd11) ^ {s[3:0], s[7:4]};
    endfunction

    always @(negedge sck) if (!cs_n) miso = resp(sb, seed_v)[7 - bitc];
    always @(posedge sck) if (!cs_n) begin
        cap  = {cap[6:0], mosi};
        bitc = bitc + 1;
        if (bitc == 8) begin
            mosi_log[sb % 32] = cap;
            sb   = sb + 1;
            bitc = 0;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_done();
        logic [7:0] s;
        for (int i = 0; i < 6000; i++) begin
            rd(8'h05, s);
            if (s[0]) break;
        end
        @(negedge clk);
    endtask

    task automatic slave_clear(input logic [7:0] s);
        sb = 0; bitc = 0; seed_v = s; cs_rise = 0;
    endtask

    task automatic summary();
        if (!summary_done) begin
            summary_done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual 0x0 expected 0x1");
        summary();
        $finish;
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1 reset state
        rd(8'h00, v); chk("R1 div", v, 8);
        rd(8'h01, v); chk("R1 fmt", v, 8'h23);
        rd(8'h02, v); chk("R1 first", v, 0);
        rd(8'h03, v); chk("R1 last", v, 0);
        rd(8'h04, v); chk("R1 ctrl", v, 0);
        rd(8'h05, v); chk("R1 status", v, 0);
        rd(8'h07, v); chk("R1 lock", v, 0);
        chk("R1 pins cs_n/sck/irq", {cs_n, sck, irq}, 3'b110);

        // table walk: R2 R3 R4 R7 R8
        for (int t = 0; t < NVEC; t++) begin
            logic [3:0] qs, qe;
            logic [7:0] dv, sd;
            int cnt;
            {qs, qe, dv, sd} = VEC[t];
            cnt = int'(4'(qe - qs)) + 1;
            wr(8'h00, dv); wr(8'h02, 8'(qs)); wr(8'h03, 8'(qe));
            for (int n = 0; n < 16; n++) begin
                wr(8'h40 + 8'(2*n), txv(n, sd));
                wr(8'h80 + 8'(n), (n == int'(qe)) ? 8'h0E : 8'h8E);
            end
            slave_clear(sd);
            wr(8'h04, 8'h60);
            for (int i = 0; i < 6000 && !irq; i++) @(negedge clk);
            chk("R8 irq at finish", irq, 1);
            rd(8'h05, v); chk("R8 status set", v, 1);
            rd(8'h04, v); chk("R7 go cleared", v, 8'h20);
            chk("R6 cs released", cs_n, 1);
            chk("R2 sck idle", sck, 1);
            chk("R4 slot count", sb, cnt);
            chk("R5 no gaps", cs_rise, 1);
            for (int k = 0; k < cnt; k++) begin
                int slot;
                slot = (int'(qs) + k) % 16;
                chk("R2/R4 mosi order", mosi_log[k], txv(slot, sd));
                rd(8'h60 + 8'(2*slot + 1), v);
                chk("R3 rx store", v, resp(k, sd));
            end
            wr(8'h05, 8'h00);
            chk("R8 irq cleared", irq, 0);
        end

        // R9 clamp and half period
        wr(8'h00, 8'd3); rd(8'h00, v); chk("R9 clamp", v, 8);
        wr(8'h00, 8'd10); wr(8'h02, 0); wr(8'h03, 0); wr(8'h80, 8'h0E);
        slave_clear(8'h01);
        wr(8'h04, 8'h40);
        begin
            int t0, t1;
            @(negedge sck); t0 = cyc;
            @(posedge sck); t1 = cyc;
            chk("R9 half period", t1 - t0, 10);
        end
        wait_done();
        // R8: irq disabled, write 1 does nothing, write 0 clears
        chk("R8 irq masked", irq, 0);
        wr(8'h05, 8'h01); rd(8'h05, v); chk("R8 write1 no effect", v, 1);
        wr(8'h05, 8'h00); rd(8'h05, v); chk("R8 write0 clears", v, 0);

        // R5 gap between slots with hold bit clear
        wr(8'h00, 8'd8); wr(8'h03, 8'd2);
        wr(8'h80, 8'h0E); wr(8'h81, 8'h8E); wr(8'h82, 8'h0E);
        slave_clear(8'h02);
        wr(8'h04, 8'h40); wait_done();
        chk("R5 cs gap count", cs_rise, 2);
        chk("R5 slots done", sb, 3);
        wr(8'h05, 8'h00);

        // R6 hold on last slot keeps cs_n low, next queue releases it
        wr(8'h03, 8'd0); wr(8'h80, 8'h8E);
        slave_clear(8'h03);
        wr(8'h04, 8'h40); wait_done();
        repeat (5) @(negedge clk);
        chk("R6 cs held", cs_n, 0);
        wr(8'h05, 8'h00); wr(8'h80, 8'h0E);
        wr(8'h04, 8'h40); wait_done();
        chk("R6 cs released later", cs_n, 1);
        wr(8'h05, 8'h00);

        // R10 R11 R7 writes during a run
        wr(8'h02, 0); wr(8'h03, 8'd15);
        for (int n = 0; n < 16; n++) wr(8'h80 + 8'(n), (n == 15) ? 8'h0E : 8'h8E);
        wr(8'h40, 8'hC3);
        slave_clear(8'h04);
        wr(8'h04, 8'h40);
        repeat (128 * 3 + 60) @(negedge clk);
        rd(8'h06, v); chk("R11 current slot", v, 3);
        rd(8'h04, v); chk("R7 go reads 1", v, 8'h40);
        wr(8'h03, 8'd0); wr(8'h40, 8'h00); wr(8'h00, 8'd20); wr(8'h8F, 8'h8E);
        rd(8'h03, v); chk("R10 last kept", v, 15);
        rd(8'h40, v); chk("R10 tx kept", v, 8'hC3);
        rd(8'h00, v); chk("R10 div kept", v, 8);
        wait_done();
        chk("R10 full queue ran", sb, 16);
        chk("R10 cmd kept, cs released", cs_n, 1);
        wr(8'h05, 8'h00);

        // R12 lock and format are plain storage
        wr(8'h07, 8'h01); rd(8'h07, v); chk("R12 lock", v, 1);
        wr(8'h01, 8'h1D); rd(8'h01, v); chk("R12 fmt", v, 8'h1D);
        wr(8'h03, 0); wr(8'h80, 8'h0E); wr(8'h40, 8'hA5);
        slave_clear(8'h05);
        wr(8'h04, 8'h40); wait_done();
        chk("R12 transfer unchanged", mosi_log[0], 8'hA5);

        summary();
        $finish;
    end
endmodule